// File: doc/BRIEF.md
# Ring Wake Detector

This block watches an incoming ring line and raises a single-cycle wake request toward the power-on controller. One of two ring pins is picked by a source-select control. Both pins are idle-high. Each pin passes through its own two-flop synchroniser. After that, a falling edge of the picked pin is the basic event the block works from.

Two detection modes are offered. In edge mode, any falling edge is a detection. In train mode, falling edges must keep arriving faster than 16 per second. That run must last for 0.19 s before a detection is reported. All timing is in clock cycles and comes from the `CLK_HZ` parameter. The gap limit is `CLK_HZ/16` cycles and the qualification window is `CLK_HZ*19/100` cycles.

An enable control gates the request. Once a request has been issued, the line must stay free of falling edges for at least the gap limit before another request can be issued. This means a ringing burst yields only one request.

Top module: `ring_wake_detect`

## Requirements
- R1: While reset is held and after it is released, with both pins idle high, `wake_o` stays 0.
- R2: `src_sel_i` = 0 picks `ring_a_i` and `src_sel_i` = 1 picks `ring_b_i`. A falling edge on the pin that is not picked produces no request.
- R3: In edge mode (`mode_i` = 0), a falling edge on the picked pin applied just after clock edge n raises `wake_o` after edge n+3: two synchroniser stages, one edge-detect stage and the output register.
- R4: In train mode (`mode_i` = 1), a request is issued only while tracking holds for the full window of WIN = `CLK_HZ*19/100` cycles. A train whose first fall is applied after edge n raises `wake_o` after edge n+3+WIN. Tracking lasts until GAP = `CLK_HZ/16` cycles have passed without a fall. A train whose last fall is L cycles after its first qualifies only if L+GAP > WIN.
- R5: In train mode, falls spaced GAP cycles or more apart never qualify. Each such fall restarts the window. Spacing of GAP-1 cycles or less keeps tracking alive.
- R6: When `en_i` = 0, no request is produced in either mode and any train in progress is dropped. When `en_i` returns to 1, the block works normally again.
- R7: After a request, no further request is issued until GAP cycles have passed without a fall on the picked pin. In edge mode, a second fall D cycles after the first produces a request only if D >= GAP.
- R8: Any change of `src_sel_i` or `mode_i` drops train qualification in progress. The next fall then starts a fresh window. A change of `src_sel_i` to a pin that is already low is not taken as a falling edge.
- R9: `wake_o` is high for exactly one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| ring_a_i | input | 1 | First ring pin, idle high, asynchronous |
| ring_b_i | input | 1 | Alternate ring pin, idle high, asynchronous |
| src_sel_i | input | 1 | 0 picks `ring_a_i`, 1 picks `ring_b_i` |
| mode_i | input | 1 | 0 edge mode, 1 train mode |
| en_i | input | 1 | 1 allows wake requests |
| wake_o | output | 1 | Single-cycle wake request |

## Verification
Every combination of select value and falling pin is applied, which separates the picked pin from the ignored one and pins down the three-cycle latency. Pairs of edge-mode falls spaced around the gap limit show where re-arming begins. Trains with periods on both sides of the gap limit show the spacing at which tracking survives. Trains of one to eight falls at a fast period locate the L+GAP > WIN boundary and the exact request cycle. A mode toggle in the middle of a train must move the request to a window started by the first fall after the toggle. Switching the select onto a pin that is already low must give no request.

// File: rtl/ring_pkg.sv
package ring_pkg;

  typedef enum logic {
    RING_EDGE  = 1'b0,
    RING_TRAIN = 1'b1
  } ring_mode_e;

  typedef struct packed {
    logic       sel;
    ring_mode_e mode;
  } ring_cfg_t;

endpackage

// File: rtl/ring_sync.sv
module ring_sync #(
  parameter int unsigned WIDTH   = 2,
  parameter logic        RST_VAL = 1'b1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] d_i,
  output logic [WIDTH-1:0] q_o
);

  for (genvar g = 0; g < WIDTH; g++) begin : g_bit
    logic meta_q;
    logic sync_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        meta_q <= RST_VAL;
        sync_q <= RST_VAL;
      end else begin
        meta_q <= d_i[g];
        sync_q <= meta_q;
      end
    end

    assign q_o[g] = sync_q;
  end

endmodule

// File: rtl/ring_edge.sv
module ring_edge
  import ring_pkg::*;
#(
  parameter int unsigned NUM_SRC = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [NUM_SRC-1:0] sync_i,
  input  ring_cfg_t          cfg_i,
  output logic               fall_o,
  output logic               cfg_chg_o
);

  logic      cur;
  logic      prev_q;
  ring_cfg_t cfg_q;

  // picked source after synchronisation
  assign cur       = sync_i[cfg_i.sel];
  assign cfg_chg_o = (cfg_i != cfg_q);
  // a select change is never taken as an edge
  assign fall_o    = prev_q & ~cur & ~cfg_chg_o;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      prev_q <= 1'b1;
      cfg_q  <= '0;
    end else begin
      prev_q <= cur;
      cfg_q  <= cfg_i;
    end
  end

endmodule

// File: rtl/ring_gap.sv
module ring_gap #(
  parameter int unsigned GAP = 2048
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  output logic expire_o,
  output logic quiet_o
);

  localparam int unsigned W   = $clog2(GAP + 1);
  localparam logic [W-1:0] LIM = W'(GAP);

  logic [W-1:0] since_q;
  logic [W-1:0] since_d;
  logic         since_en;

  assign quiet_o  = (since_q == LIM);
  // next update brings the count to the limit
  assign expire_o = !fall_i && (since_q == (LIM - W'(1)));
  assign since_en = fall_i | ~quiet_o;

  always_comb begin
    since_d = since_q + W'(1);
    if (fall_i) begin
      since_d = W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      since_q <= LIM;
    end else if (since_en) begin
      since_q <= since_d;
    end
  end

  // R5
  quiet_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(quiet_o) |-> $past(expire_o));

endmodule

// File: rtl/ring_train.sv
module ring_train #(
  parameter int unsigned WIN = 6225
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fall_i,
  input  logic expire_i,
  input  logic quiet_i,
  input  logic clr_i,
  output logic det_o
);

  localparam int unsigned W   = $clog2(WIN + 1);
  localparam logic [W-1:0] LIM = W'(WIN);

  logic         trk_q;
  logic         trk_d;
  logic [W-1:0] win_q;
  logic [W-1:0] win_d;
  logic         upd_en;

  assign upd_en = clr_i | fall_i | expire_i | trk_q;

  always_comb begin
    trk_d = trk_q;
    win_d = win_q;
    if (clr_i) begin
      trk_d = 1'b0;
      win_d = '0;
    end else if (fall_i && !trk_q) begin
      trk_d = 1'b1;
      win_d = W'(1);
    end else if (expire_i) begin
      trk_d = 1'b0;
      win_d = '0;
    end else if (trk_q && (win_q != LIM)) begin
      win_d = win_q + W'(1);
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      trk_q <= 1'b0;
      win_q <= '0;
    end else if (upd_en) begin
      trk_q <= trk_d;
      win_q <= win_d;
    end
  end

  assign det_o = trk_q && (win_q == LIM);

  // R5
  gap_guard_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    trk_q |-> !quiet_i);

  // R8
  cfg_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> !trk_q);

  // R4
  det_entry_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(det_o) |-> $past(trk_q));

endmodule

// File: rtl/ring_wake_detect.sv
module ring_wake_detect
  import ring_pkg::*;
#(
  parameter int unsigned CLK_HZ = 32768
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic ring_a_i,
  input  logic ring_b_i,
  input  logic src_sel_i,
  input  logic mode_i,
  input  logic en_i,
  output logic wake_o
);

  localparam int unsigned GAP     = CLK_HZ / 16;
  localparam int unsigned WIN     = (CLK_HZ * 19) / 100;
  localparam int unsigned NUM_SRC = 2;

  // reset: asserted asynchronously, released on the clock
  logic rst_meta_q;
  logic rst_n;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rst_meta_q <= 1'b0;
      rst_n      <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_n      <= rst_meta_q;
    end
  end

  logic [NUM_SRC-1:0] pins;
  logic [NUM_SRC-1:0] pins_sync;
  ring_cfg_t          cfg;
  logic               fall;
  logic               cfg_chg;
  logic               expire;
  logic               quiet;
  logic               clr;
  logic               train_det;
  logic               det;

  assign pins     = {ring_b_i, ring_a_i};
  assign cfg.sel  = src_sel_i;
  assign cfg.mode = ring_mode_e'(mode_i);

  ring_sync #(.WIDTH(NUM_SRC), .RST_VAL(1'b1)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_n),
    .d_i    (pins),
    .q_o    (pins_sync)
  );

  ring_edge #(.NUM_SRC(NUM_SRC)) u_edge (
    .clk_i     (clk_i),
    .rst_ni    (rst_n),
    .sync_i    (pins_sync),
    .cfg_i     (cfg),
    .fall_o    (fall),
    .cfg_chg_o (cfg_chg)
  );

  ring_gap #(.GAP(GAP)) u_gap (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .fall_i   (fall),
    .expire_o (expire),
    .quiet_o  (quiet)
  );

  assign clr = cfg_chg | ~en_i | (cfg.mode != RING_TRAIN);

  ring_train #(.WIN(WIN)) u_train (
    .clk_i    (clk_i),
    .rst_ni   (rst_n),
    .fall_i   (fall),
    .expire_i (expire),
    .quiet_i  (quiet),
    .clr_i    (clr),
    .det_o    (train_det)
  );

  assign det = (cfg.mode == RING_TRAIN) ? train_det : fall;

  // one request per burst, re-armed by a quiet gap
  logic armed_q;
  logic armed_d;
  logic wake_q;
  logic wake_d;

  always_comb begin
    wake_d  = en_i & armed_q & det;
    armed_d = armed_q;
    if (expire) begin
      armed_d = 1'b1;
    end else if (wake_d) begin
      armed_d = 1'b0;
    end
  end

  always_ff @(posedge clk_i or negedge rst_n) begin
    if (!rst_n) begin
      armed_q <= 1'b1;
      wake_q  <= 1'b0;
    end else begin
      armed_q <= armed_d;
      wake_q  <= wake_d;
    end
  end

  assign wake_o = wake_q;

  // R9
  wake_single_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_q |=> !wake_q);

  // R7
  rearm_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    wake_q |-> (!armed_q || quiet));

  // R7
  rearm_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_n)
    $rose(armed_q) |-> quiet);

endmodule

// File: tb/sim_ring_wake_detect.sv
module sim_ring_wake_detect;

  localparam int unsigned CLK_HZ = 800;
  localparam int GAP = CLK_HZ / 16;
  localparam int WIN = (CLK_HZ * 19) / 100;
  localparam int LAT = 3;

  logic clk   = 1'b0;
  logic rst_n = 1'b0;
  logic ring_a = 1'b1;
  logic ring_b = 1'b1;
  logic sel   = 1'b0;
  logic mode  = 1'b0;
  logic en    = 1'b1;
  logic wake;

  int cyc = 0;
  int wake_cnt = 0;
  int last_wake = -1;
  int run = 0;
  int max_run = 0;
  int n_chk = 0;
  int n_bad = 0;
  int t0 = 0;

  always #10 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  always @(negedge clk) begin
    if (wake === 1'b1) begin
      wake_cnt  = wake_cnt + 1;
      last_wake = cyc;
      run       = run + 1;
      if (run > max_run) max_run = run;
    end else begin
      run = 0;
    end
  end

  ring_wake_detect #(.CLK_HZ(CLK_HZ)) u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .ring_a_i  (ring_a),
    .ring_b_i  (ring_b),
    .src_sel_i (sel),
    .mode_i    (mode),
    .en_i      (en),
    .wake_o    (wake)
  );

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic tick(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic set_pin(input int p, input logic v);
    if (p == 0) ring_a = v;
    else        ring_b = v;
  endtask

  task automatic clear_log();
    wake_cnt  = 0;
    last_wake = -1;
  endtask

  task automatic pulse(input int p);
    @(negedge clk);
    t0 = cyc;
    set_pin(p, 1'b0);
    tick(2);
    set_pin(p, 1'b1);
  endtask

  task automatic train(input int p, input int nf, input int per);
    for (int i = 0; i < nf; i++) begin
      @(negedge clk);
      if (i == 0) t0 = cyc;
      set_pin(p, 1'b0);
      tick(per / 2);
      set_pin(p, 1'b1);
      tick(per - per / 2 - 1);
    end
  endtask

  task automatic finish_run();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    // R1: reset state
    tick(3);
    check("R1 during reset", int'(wake), 0);
    @(negedge clk);
    rst_n = 1'b1;
    tick(GAP + 10);
    check("R1 after release", wake_cnt, 0);

    // R2, R3: every select value against every falling pin
    for (int s = 0; s < 2; s++) begin
      for (int p = 0; p < 2; p++) begin
        sel = s[0];
        tick(3);
        clear_log();
        pulse(p);
        tick(GAP + 10);
        check("R2 pin pick count", wake_cnt, (p == s) ? 1 : 0);
        if (p == s) check("R3 edge latency", last_wake, t0 + LAT);
      end
    end

    // R7: second fall spaced around the gap limit
    sel = 1'b0;
    tick(3);
    for (int d = GAP - 2; d <= GAP + 1; d++) begin
      clear_log();
      pulse(0);
      tick(d - 3);
      pulse(0);
      tick(GAP + 10);
      check("R7 rearm spacing", wake_cnt, (d >= GAP) ? 2 : 1);
    end

    // R6: disabled in both modes, then enabled again
    en = 1'b0;
    tick(2);
    clear_log();
    pulse(0);
    tick(GAP + 10);
    check("R6 edge disabled", wake_cnt, 0);
    mode = 1'b1;
    tick(2);
    train(0, 10, 20);
    tick(GAP + 10);
    check("R6 train disabled", wake_cnt, 0);
    en = 1'b1;
    mode = 1'b0;
    tick(GAP + 10);
    clear_log();
    pulse(0);
    tick(10);
    check("R6 re-enabled", wake_cnt, 1);
    tick(GAP);

    // R4, R5: train period around the gap limit
    mode = 1'b1;
    tick(3);
    for (int per = GAP - 2; per <= GAP + 1; per++) begin
      clear_log();
      train(0, 8, per);
      tick(GAP + 10);
      check("R5 period count", wake_cnt, (per < GAP) ? 1 : 0);
      if (per < GAP) check("R4 train latency", last_wake, t0 + LAT + WIN);
    end

    // R4: train length around the window
    for (int k = 1; k <= 8; k++) begin
      clear_log();
      train(0, k, 20);
      tick(GAP + WIN);
      check("R4 train length", wake_cnt, ((k - 1) * 20 + GAP > WIN) ? 1 : 0);
    end

    // R8: mode toggle mid-train restarts the window
    clear_log();
    train(0, 4, 20);
    @(negedge clk);
    mode = 1'b0;
    @(negedge clk);
    mode = 1'b1;
    train(0, 12, 20);
    tick(GAP + 10);
    check("R8 toggle count", wake_cnt, 1);
    check("R8 toggle restart", last_wake, t0 + LAT + WIN);

    // R8: select onto a pin already low is no edge
    mode = 1'b0;
    tick(3);
    ring_b = 1'b0;
    tick(GAP + 10);
    clear_log();
    sel = 1'b1;
    tick(10);
    check("R8 select switch", wake_cnt, 0);
    ring_b = 1'b1;
    tick(3);
    sel = 1'b0;
    tick(GAP + 10);

    // R9: every request one cycle wide
    check("R9 pulse width", max_run, 1);

    finish_run();
  end

endmodule